// File: doc/BRIEF.md
# Interval Timer Register Interface

This block is the software-facing front end of a three-channel interval timer. A host reaches it through a byte-wide port with a 2-bit address, separate write and read strobes, and 8-bit data in each direction. Addresses 0, 1 and 2 reach the count of channels 0, 1 and 2. Address 3 takes control bytes. A control byte can program one channel, freeze one channel's count, or snapshot the count and status of several channels at once.

For each channel the block holds the programmed byte-access style, the operating mode, the decimal-counting flag, and a byte pointer for writes and another for reads. It also holds one frozen count and one frozen status byte, plus a flag saying a loaded count has not yet reached the counter. It reads each channel's live count and output level. It returns a 16-bit start value and a one-cycle load pulse to each channel. The counting engines themselves sit outside this block.

Top module: `timer_ctl_if`

## Requirements
- R1: After reset, every channel uses two-byte access (low byte, then high byte) in mode 0 with binary counting. No frozen count or status is pending, no load pulse is active, and the pending-load flag is clear.
- R2: A control byte at address 3 whose bits 7:6 are 0, 1 or 2 and whose bits 5:4 are not zero programs that channel. Bits 5:4 set the access style (1 = low byte only, 2 = high byte only, 3 = low then high). Bits 3:1 set the mode and bit 0 sets decimal counting. Both byte pointers of that channel return to the low byte.
- R3: A count byte written to a channel address loads `{8'h00, byte}` in low-only access and `{byte, 8'h00}` in high-only access. In two-byte access the first byte is held and `{second, first}` loads on the second byte. The load pulse and value appear on the clock edge that takes the completing write.
- R4: At most one channel's load pulse is high in any cycle. A pulse occurs only in the cycle after a count write.
- R5: A control byte with bits 5:4 equal to zero freezes the live count of the channel in bits 7:6. Later changes of the live count do not alter the frozen value.
- R6: A command to freeze a count is ignored while that channel still holds an unread frozen count. A command to freeze status is ignored while that channel still holds an unread frozen status.
- R7: A control byte with bits 7:6 equal to 3 is a snapshot command. Bits 1, 2 and 3 pick channels 0, 1 and 2. Bit 5 low freezes the count and bit 4 low freezes the status of every picked channel.
- R8: A channel read returns the frozen status if one is pending, else the frozen count if one is pending, else the live count. Each frozen item is released once it has been fully read.
- R9: A frozen count is read as one byte in low-only or high-only access. In two-byte access it is read as the low byte, then the high byte. Live reads in two-byte access alternate low and high bytes, starting with the low byte.
- R10: The status byte is {output level in bit 7, pending-load flag in bit 6, access style in bits 5:4, mode in bits 3:1, decimal flag in bit 0}, taken when it is frozen.
- R11: The pending-load flag of a channel is set by a load to that channel. It is cleared when that channel's load-acknowledge input is high and no new load occurs in the same cycle.
- R12: A read at address 3 returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address: 0 to 2 select a channel count, 3 selects control |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe, one byte per cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle rd_en is high |
| live_count | input | 48 | Current count of each channel, 16 bits per channel, channel 0 in the low bits |
| ch_out | input | 3 | Output level of each channel |
| load_ack | input | 3 | Per channel: the counter has taken its loaded value |
| load_val | output | 48 | Start value for each channel, 16 bits per channel |
| load_stb | output | 3 | One-cycle load pulse for each channel |

## Verification
On every cycle, the assertions check that load pulses are one-hot and follow a count write. They also check that a read at address 3 returns zero and leaves every frozen item untouched. Finally, they check that a pending frozen count survives until a read of its own channel, and that a status read releases the frozen status. The bench scenarios cover the rest. Byte assembly for each access style, pointer restart on a control write, the value frozen against a live count that has since changed, the status-then-count-then-live order, multi-channel snapshots, and the life cycle of the pending-load flag can only be shown by comparing returned bytes with expected ones.

// File: rtl/timer_ctl_if.sv
`timescale 1ns/1ps
module timer_ctl_if #(
  parameter int NCH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic [NCH*16-1:0]  live_count,
  input  logic [NCH-1:0]     ch_out,
  input  logic [NCH-1:0]     load_ack,
  output logic [NCH*16-1:0]  load_val,
  output logic [NCH-1:0]     load_stb
);
  localparam int W = 16;

  logic       ctl_wr;
  logic       is_snap;
  logic [1:0] sel;
  logic [7:0] chan_byte [NCH];
  logic [NCH-1:0] st_pend_v;
  logic [NCH-1:0] lat_busy_v;

  assign ctl_wr  = wr_en && (addr == 2'd3);
  assign sel     = wdata[7:6];
  assign is_snap = (sel == 2'd3);

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    logic [1:0]   acc_q;
    logic [2:0]   mode_q;
    logic         bcd_q;
    logic         rd_hi_q, wr_hi_q;
    logic [7:0]   hold_q;
    logic [W-1:0] lat_q;
    logic [1:0]   lat_st_q;
    logic         st_pend_q;
    logic [7:0]   st_q;
    logic         null_q;
    logic [W-1:0] ld_val_q;
    logic         ld_stb_q;

    logic         set_ctl, latch_cnt, latch_st, cnt_wr, cnt_rd, do_load;
    logic [W-1:0] live, new_val;
    logic [7:0]   status_now;

    assign live       = live_count[gi*W +: W];
    assign set_ctl    = ctl_wr && !is_snap && (sel == 2'(gi)) && (wdata[5:4] != 2'd0);
    assign latch_cnt  = ctl_wr && (is_snap ? (wdata[1+gi] && !wdata[5])
                                           : ((sel == 2'(gi)) && (wdata[5:4] == 2'd0)));
    assign latch_st   = ctl_wr && is_snap && wdata[1+gi] && !wdata[4];
    assign cnt_wr     = wr_en && (addr == 2'(gi));
    assign cnt_rd     = rd_en && (addr == 2'(gi));
    assign do_load    = cnt_wr && ((acc_q != 2'd3) || wr_hi_q);
    assign new_val    = (acc_q == 2'd1) ? {8'h00, wdata} :
                        (acc_q == 2'd2) ? {wdata, 8'h00} : {wdata, hold_q};
    assign status_now = {ch_out[gi], null_q, acc_q, mode_q, bcd_q};

    always_comb begin
      if (st_pend_q)                 chan_byte[gi] = st_q;
      else if (lat_st_q != 2'd0)     chan_byte[gi] = (lat_st_q == 2'd2) ? lat_q[15:8] : lat_q[7:0];
      else if (acc_q == 2'd1)        chan_byte[gi] = live[7:0];
      else if (acc_q == 2'd2)        chan_byte[gi] = live[15:8];
      else                           chan_byte[gi] = rd_hi_q ? live[15:8] : live[7:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_q     <= 2'd3;
        mode_q    <= 3'd0;
        bcd_q     <= 1'b0;
        rd_hi_q   <= 1'b0;
        wr_hi_q   <= 1'b0;
        hold_q    <= 8'h00;
        lat_q     <= '0;
        lat_st_q  <= 2'd0;
        st_pend_q <= 1'b0;
        st_q      <= 8'h00;
        null_q    <= 1'b0;
        ld_val_q  <= '0;
        ld_stb_q  <= 1'b0;
      end else begin
        if (set_ctl) begin
          acc_q   <= wdata[5:4];
          mode_q  <= wdata[3:1];
          bcd_q   <= wdata[0];
          rd_hi_q <= 1'b0;
          wr_hi_q <= 1'b0;
        end

        if (cnt_rd) begin
          if (st_pend_q)                st_pend_q <= 1'b0;
          else if (lat_st_q != 2'd0)    lat_st_q  <= (lat_st_q == 2'd3) ? 2'd2 : 2'd0;
          else if (acc_q == 2'd3)       rd_hi_q   <= !rd_hi_q;
        end

        if (latch_cnt && lat_st_q == 2'd0) begin
          lat_q    <= live;
          lat_st_q <= acc_q;
        end
        if (latch_st && !st_pend_q) begin
          st_q      <= status_now;
          st_pend_q <= 1'b1;
        end

        if (cnt_wr && acc_q == 2'd3) begin
          if (!wr_hi_q) hold_q <= wdata;
          wr_hi_q <= !wr_hi_q;
        end

        ld_stb_q <= do_load;
        if (do_load) ld_val_q <= new_val;
        if (do_load)          null_q <= 1'b1;
        else if (load_ack[gi]) null_q <= 1'b0;
      end
    end

    assign load_val[gi*W +: W] = ld_val_q;
    assign load_stb[gi]        = ld_stb_q;
    assign st_pend_v[gi]       = st_pend_q;
    assign lat_busy_v[gi]      = (lat_st_q != 2'd0);
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NCH; i++)
      if (rd_en && addr == 2'(i)) rdata = chan_byte[i];
  end
endmodule

// File: rtl/timer_ctl_if_chk.sv
`timescale 1ns/1ps
module timer_ctl_if_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     addr,
  input logic           wr_en,
  input logic           rd_en,
  input logic [7:0]     rdata,
  input logic [NCH-1:0] load_stb,
  input logic [NCH-1:0] st_pend_v,
  input logic [NCH-1:0] lat_busy_v
);
  assert_single_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb));

  assert_load_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb != '0) |-> $past(wr_en && addr != 2'd3));

  assert_ctrl_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |-> (rdata == 8'h00));

  assert_ctrl_read_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 2'd3) |=> ($stable(st_pend_v) && $stable(lat_busy_v)));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_latch_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_busy_v[i] && !(rd_en && addr == 2'(i))) |=> lat_busy_v[i]);

    assert_status_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 2'(i) && st_pend_v[i]) |=> !st_pend_v[i]);
  end
endmodule

bind timer_ctl_if timer_ctl_if_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .load_stb(load_stb), .st_pend_v(st_pend_v), .lat_busy_v(lat_busy_v)
);

// File: tb/tb_timer_ctl_if.sv
`timescale 1ns/1ps
module tb_timer_ctl_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [47:0] live_count = 48'h5A0F_ABCD_1234;
  logic [2:0]  ch_out = 3'b101;
  logic [2:0]  load_ack = 3'b000;
  logic [47:0] load_val;
  logic [2:0]  load_stb;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  timer_ctl_if #(.NCH(3)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .live_count(live_count), .ch_out(ch_out),
    .load_ack(load_ack), .load_val(load_val), .load_stb(load_stb)
  );

  // {addr[1:0], wr, rd, data[7:0], expected[7:0]}
  localparam int NV = 15;
  localparam logic [19:0] VEC [NV] = '{
    {2'd3, 1'b1, 1'b0, 8'h34, 8'h00},
    {2'd0, 1'b0, 1'b1, 8'h00, 8'h34},
    {2'd0, 1'b0, 1'b1, 8'h00, 8'h12},
    {2'd0, 1'b0, 1'b1, 8'h00, 8'h34},
    {2'd3, 1'b1, 1'b0, 8'h51, 8'h00},
    {2'd1, 1'b0, 1'b1, 8'h00, 8'hCD},
    {2'd1, 1'b0, 1'b1, 8'h00, 8'hCD},
    {2'd3, 1'b1, 1'b0, 8'hA6, 8'h00},
    {2'd2, 1'b0, 1'b1, 8'h00, 8'h5A},
    {2'd3, 1'b0, 1'b1, 8'h00, 8'h00},
    {2'd3, 1'b1, 1'b0, 8'hEE, 8'h00},
    {2'd0, 1'b0, 1'b1, 8'h00, 8'hB4},
    {2'd1, 1'b0, 1'b1, 8'h00, 8'h11},
    {2'd2, 1'b0, 1'b1, 8'h00, 8'hA6},
    {2'd0, 1'b0, 1'b1, 8'h00, 8'h12}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 got = rdata;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, {8'h00, got}, {8'h00, exp});
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 no load pulse", {13'd0, load_stb}, 16'd0);
    rd(2'd0, 8'h34, "R1 live low byte in word access");
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'hB0, "R1 reset status");
    rd(2'd0, 8'h12, "R1 live high byte after low");

    // vector table: R2 R9 R10 R12
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17]) wr(VEC[i][19:18], VEC[i][15:8]);
      else rd(VEC[i][19:18], VEC[i][7:0], $sformatf("R10 table step %0d", i));
    end

    // R3 / R11 word load and pending-load flag
    wr(2'd3, 8'h34);
    wr(2'd0, 8'h78);
    check("R3 no load after first byte", {13'd0, load_stb}, 16'd0);
    wr(2'd0, 8'h56);
    check("R4 ch0 pulse only", {13'd0, load_stb}, 16'd1);
    check("R3 word value", load_val[15:0], 16'h5678);
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'hF4, "R11 flag set after load");
    @(negedge clk); load_ack = 3'b001;
    @(negedge clk); load_ack = 3'b000;
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'hB4, "R11 flag cleared by ack");

    // R3 low-only and high-only
    wr(2'd3, 8'h51);
    wr(2'd1, 8'h9C);
    check("R3 ch1 pulse", {13'd0, load_stb}, 16'd2);
    check("R3 low-only value", load_val[31:16], 16'h009C);
    wr(2'd3, 8'hA6);
    wr(2'd2, 8'h3E);
    check("R3 ch2 pulse", {13'd0, load_stb}, 16'd4);
    check("R3 high-only value", load_val[47:32], 16'h3E00);

    // R2 write pointer restart
    wr(2'd3, 8'h34);
    wr(2'd0, 8'hAA);
    wr(2'd3, 8'h34);
    wr(2'd0, 8'h11);
    check("R2 pointer restarted no load", {13'd0, load_stb}, 16'd0);
    wr(2'd0, 8'h22);
    check("R2 value after restart", load_val[15:0], 16'h2211);

    // R2 read pointer restart
    live_count[15:0] = 16'hBEEF;
    rd(2'd0, 8'hEF, "R9 live low");
    wr(2'd3, 8'h34);
    rd(2'd0, 8'hEF, "R2 read pointer restart");
    rd(2'd0, 8'hBE, "R9 live high");

    // R5 / R6 / R9 / R12 frozen count
    wr(2'd3, 8'h00);
    live_count[15:0] = 16'h1357;
    wr(2'd3, 8'h00);
    rd(2'd0, 8'hEF, "R5 frozen low");
    rd(2'd3, 8'h00, "R12 control read zero");
    rd(2'd0, 8'hBE, "R6 second freeze ignored, frozen high");
    rd(2'd0, 8'h57, "R8 released, live low");
    rd(2'd0, 8'h13, "R9 live high");

    // R7 snapshot of ch1 and ch2, count and status
    live_count[47:16] = 32'h8765_4321;
    wr(2'd3, 8'hCC);
    live_count[47:16] = 32'h0000_0000;
    rd(2'd2, 8'hE6, "R7 ch2 status first");
    rd(2'd2, 8'h87, "R7 ch2 frozen high byte");
    rd(2'd2, 8'h00, "R8 ch2 live after release");
    rd(2'd1, 8'h51, "R7 ch1 status first");
    rd(2'd1, 8'h21, "R7 ch1 frozen low byte");
    rd(2'd1, 8'h00, "R8 ch1 live after release");

    // R6 status freeze ignored while pending
    wr(2'd3, 8'hE2);
    ch_out = 3'b100;
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'hF4, "R6 old status kept");
    rd(2'd0, 8'h57, "R8 live after status");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule